// File: doc/BRIEF.md
# Longest Prefix Match Lookup

This block is a small forwarding lookup engine for a routed switch. A table of entries is held in registers. Each entry stores a destination prefix, the number of leading address bits that prefix covers, an output port and a valid bit. Entries are loaded through a single-cycle write port. Each lookup request carries an 8-bit destination address. That address is compared against every valid entry in parallel, and the output port of the most specific matching entry is returned.

A zero-length entry matches every address, so it serves as the default route. A mode input replaces the longest-prefix search with an exact comparison on a fixed number of leading bits. Requests and responses each use a valid/ready handshake. The engine accepts one request per cycle and returns each result one cycle after acceptance.

Top module: `lpm_lookup`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low and `req_ready` is high.
- R2: A write updates the entry at `wr_idx` at the clock edge where `wr_en` is high. A lookup accepted at that same edge still sees the previous contents of the entry, and a lookup accepted at the next edge sees the new contents.
- R3: An entry of length L matches an address when the L most significant bits of the address equal the L most significant bits of the stored prefix. Prefix bits below the top L are ignored.
- R4: When several valid entries match, the result is the port of the matching entry with the greatest length.
- R5: Among matching entries of equal length, the entry with the lowest index wins.
- R6: A length-0 entry matches any address, and it is chosen only when no longer entry matches.
- R7: When no valid entry matches, the response has `rsp_miss` = 1 and `rsp_port` = 0. On a hit, `rsp_miss` = 0.
- R8: With `fixed_mode` = 1, an entry matches only if its length equals `fixed_len` and its top `fixed_len` bits equal those of the address. Shorter entries, including the default, do not match. Ties go to the lowest index.
- R9: A request accepted at one edge (`req_valid` and `req_ready` high) has its response valid after that same edge. A new request can be accepted on every cycle.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_port` and `rsp_miss` hold their values.
- R11: An entry written with `wr_valid` = 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | 3 | Entry index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_prefix | input | 8 | Prefix, left-aligned (MSB first) |
| wr_len | input | 4 | Prefix length 0..8; larger values are clamped to 8 |
| wr_port | input | 3 | Output port for the entry |
| fixed_mode | input | 1 | 1 selects fixed-length exact matching |
| fixed_len | input | 4 | Length compared in fixed mode |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 8 | Destination address to look up |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_port | output | 3 | Selected output port (0 on miss) |
| rsp_miss | output | 1 | No entry matched |

## Verification
Each result is due exactly one clock edge after its request is accepted, and each table write becomes visible to a lookup accepted one edge after the write edge. The bench drives inputs at falling edges, so every sample lands half a period after the edge that produces the result. A back-to-back test checks two results on consecutive falling edges. A stall test holds `rsp_ready` low for two edges and checks, at each falling edge, that the result is unchanged and that `req_ready` is low. It then checks that the queued request completes one edge after `rsp_ready` returns high.

// File: rtl/lpm_lookup.sv
module lpm_lookup #(
  parameter int ADDR_W  = 8,
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 3,
  localparam int LEN_W  = $clog2(ADDR_W + 1),
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_prefix,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              fixed_mode,
  input  logic [LEN_W-1:0]  fixed_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PORT_W-1:0] rsp_port,
  output logic              rsp_miss
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(ADDR_W);

  function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++)
      m[b] = (ADDR_W - b) <= int'(len);
    return m;
  endfunction

  logic              ent_vld  [ENTRIES];
  logic [ADDR_W-1:0] ent_pfx  [ENTRIES];
  logic [LEN_W-1:0]  ent_len  [ENTRIES];
  logic [PORT_W-1:0] ent_port [ENTRIES];

  logic [LEN_W-1:0] wr_len_c;
  assign wr_len_c = (wr_len > MAX_LEN) ? MAX_LEN : wr_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_vld[i]  <= 1'b0;
        ent_pfx[i]  <= '0;
        ent_len[i]  <= '0;
        ent_port[i] <= '0;
      end
    end else if (wr_en) begin
      ent_vld[wr_idx]  <= wr_valid;
      ent_pfx[wr_idx]  <= wr_prefix & len_mask(wr_len_c);
      ent_len[wr_idx]  <= wr_len_c;
      ent_port[wr_idx] <= wr_port;
    end
  end

  logic [ENTRIES-1:0] hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic len_ok;
    assign len_ok = !fixed_mode || (ent_len[i] == fixed_len);
    assign hit[i] = ent_vld[i] && len_ok &&
                    ((req_addr & len_mask(ent_len[i])) == ent_pfx[i]);
  end

  logic             found;
  logic [LEN_W-1:0] best_len;
  logic [IDX_W-1:0] best_idx;

  always_comb begin
    found    = 1'b0;
    best_len = '0;
    best_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i] && (!found || ent_len[i] >= best_len)) begin
        found    = 1'b1;
        best_len = ent_len[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_port  <= '0;
      rsp_miss  <= 1'b0;
    end else if (req_valid && req_ready) begin
      rsp_valid <= 1'b1;
      rsp_port  <= found ? ent_port[best_idx] : '0;
      rsp_miss  <= !found;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/lpm_lookup_chk.sv
module lpm_lookup_chk #(
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PORT_W-1:0] rsp_port,
  input logic              rsp_miss
);

  // R1
  rst_idle_chk: assert property (@(posedge clk) !$past(rst_n) |-> !rsp_valid);

  // R9
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(req_valid && req_ready)) |-> $past(rsp_valid && !rsp_ready));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_port) && $stable(rsp_miss)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R7
  miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_port == '0));

endmodule

bind lpm_lookup lpm_lookup_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_port(rsp_port),
  .rsp_miss(rsp_miss)
);

// File: tb/lpm_lookup_bench.sv
module lpm_lookup_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_valid = 1'b0;
  logic [2:0] wr_idx = '0, wr_port = '0;
  logic [7:0] wr_prefix = '0, req_addr = '0;
  logic [3:0] wr_len = '0, fixed_len = '0;
  logic       fixed_mode = 1'b0, req_valid = 1'b0, rsp_ready = 1'b1;
  logic       req_ready, rsp_valid, rsp_miss;
  logic [2:0] rsp_port;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_lookup u_lpm_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
    .fixed_mode(fixed_mode), .fixed_len(fixed_len), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_port(rsp_port), .rsp_miss(rsp_miss)
  );

  task automatic chk(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_rsp(input string tag, input int port, input int miss);
    chk({tag, " valid"}, int'(rsp_valid), 1);
    chk({tag, " port"}, int'(rsp_port), port);
    chk({tag, " miss"}, int'(rsp_miss), miss);
  endtask

  task automatic write(input int idx, input int vld, input int pfx, input int len, input int port);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_valid = 1'(vld);
    wr_prefix = 8'(pfx); wr_len = 4'(len); wr_port = 3'(port);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input string tag, input int addr, input int port, input int miss);
    @(negedge clk);
    req_valid = 1; req_addr = 8'(addr);
    @(negedge clk);
    chk_rsp(tag, port, miss);
    req_valid = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);
    rst_n = 1;
    lookup("R1 empty table", 8'hA5, 0, 1);
  endtask

  task automatic t_longest;
    write(0, 1, 8'b1101_1111, 4, 1);
    write(1, 1, 8'b1000_0000, 1, 2);
    write(2, 1, 8'b1100_1000, 7, 3);
    write(3, 1, 8'b0110_0000, 4, 4);
    write(4, 1, 8'h00, 0, 5);
    lookup("R3 masked prefix bits", 8'b1101_1001, 1, 0);
    lookup("R4 len7 beats len1", 8'b1100_1001, 3, 0);
    lookup("R4 only len1", 8'b1000_0000, 2, 0);
    lookup("R3 other branch", 8'b0110_0101, 4, 0);
    lookup("R6 default", 8'b0000_0000, 5, 0);
  endtask

  task automatic t_tie_invalid;
    write(5, 1, 8'b1101_0000, 4, 6);
    lookup("R5 tie lowest index", 8'b1101_0000, 1, 0);
    write(0, 0, 8'b1101_0000, 4, 1);
    lookup("R11 invalid entry skipped", 8'b1101_0000, 6, 0);
  endtask

  task automatic t_miss;
    write(4, 0, 8'h00, 0, 5);
    lookup("R7 miss without default", 8'b0000_0000, 0, 1);
  endtask

  task automatic t_fixed;
    fixed_mode = 1; fixed_len = 4;
    lookup("R8 fixed exact len4", 8'b1101_1001, 6, 0);
    lookup("R8 fixed ignores other lengths", 8'b1100_1001, 0, 1);
    lookup("R8 fixed second entry", 8'b0110_1111, 4, 0);
    fixed_mode = 0;
  endtask

  task automatic t_full_len;
    write(6, 1, 8'b1010_1010, 8, 7);
    lookup("R3 full length exact", 8'b1010_1010, 7, 0);
    lookup("R4 fall back to len1", 8'b1010_1011, 2, 0);
  endtask

  task automatic t_write_race;
    @(negedge clk);
    wr_en = 1; wr_idx = 3; wr_valid = 1; wr_prefix = 8'b0110_0000; wr_len = 4; wr_port = 7;
    req_valid = 1; req_addr = 8'b0110_0101;
    @(negedge clk);
    chk_rsp("R2 same-edge lookup sees old", 4, 0);
    wr_en = 0; req_valid = 0;
    lookup("R2 next lookup sees new", 8'b0110_0101, 7, 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1; req_addr = 8'b1010_1010;
    @(negedge clk);
    chk_rsp("R9 first of pair", 7, 0);
    req_addr = 8'b1101_1001;
    @(negedge clk);
    chk_rsp("R9 second of pair", 6, 0);
    req_valid = 0;
  endtask

  task automatic t_stall;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 8'b1000_0000;
    @(negedge clk);
    chk_rsp("R10 first result", 2, 0);
    chk("R10 req_ready low", int'(req_ready), 0);
    req_addr = 8'b0110_0000;
    @(negedge clk);
    chk_rsp("R10 held result", 2, 0);
    chk("R10 req_ready still low", int'(req_ready), 0);
    rsp_ready = 1;
    @(negedge clk);
    chk_rsp("R10 queued request", 7, 0);
    req_valid = 0;
    @(negedge clk);
    chk("R9 idle after drain", int'(rsp_valid), 0);
  endtask

  initial begin
    t_reset();
    t_longest();
    t_tie_invalid();
    t_miss();
    t_fixed();
    t_full_len();
    t_write_race();
    t_back_to_back();
    t_stall();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule